// File: doc/BRIEF.md
# SATA Port Bring-Up Sequencer

This block is a hardware sequencer that takes a serial-ATA host controller from power-on to a usable state with no processor help. On a start pulse it resets the controller, reads how many ports it has and which of them are implemented, then visits each implemented port in ascending order. For each port it stops any running engines, requests spin-up, waits for the physical link and then for the attached device to stop being busy. It then clears latched error and interrupt status and records whether the link is live.

All controller accesses go out over a simple request/acknowledge register master. Every wait is measured in pulses of a millisecond tick input, so the budgets are independent of the clock frequency. A port whose link never comes up is skipped without failing the run. A port that reports a fresh reset handshake after the device wait is rerun from the top, with a capped number of retries. The only fatal condition is a controller reset that never completes.

Top module: `sata_bringup_seq`

## Requirements
- R1: Out of reset `done`, `fail`, `link_map` and `bus_req` are 0. A `start` pulse is accepted only while idle and clears `done`, `fail` and `link_map`. A `start` during a run is ignored, so the capability register is read once per run.
- R2: Global reset reads host control (address 0x01) and writes it back with bit 0 set. Bit 0 is then re-read once per tick. When it reads clear, the run goes on. If it is still set on the RST_POLLS-th poll, `fail` and `done` rise and no port register is touched. The control register is read 1 + RST_POLLS times in total in that case.
- R3: The port count is capability (0x00) bits [4:0] plus one, clamped to MAX_PORTS. Only ports whose bit is set in the implemented mask (0x02) are accessed, and in ascending order. Port p's registers sit at 0x10 + 8p: command +0, status +1, error +2, task-file +3, interrupt +4.
- R4: If the command register shows any of bits 0, 4, 14 or 15, it is written with those four bits cleared and all others kept. The next command access comes at least DEACT_TICKS ticks later.
- R5: Spin-up writes the command value just read with bit 1 set and every other bit unchanged.
- R6: The link is ready when status bits [3:0] equal 3. Status is read at most LINK_POLLS times, one tick apart. A port that never shows 3 gets no further access, no map bit and no `fail`.
- R7: Right after link-up, a nonzero error register is written back with the value read.
- R8: The device wait reads task-file status and ends when bits 7 (busy) and 3 (data request) are both clear. Otherwise it waits a tick and reads status, ending if the detect field is 3. It performs at most SPIN_POLLS task-file reads.
- R9: If the detect field reads 1 after the device wait, the port restarts from its command read. This happens at most MAX_RETRY times per port, so spin-up is written at most MAX_RETRY+1 times.
- R10: Cleanup writes back the error value read (always) and the interrupt status read (only if nonzero). It then writes the host interrupt status (0x03) with exactly the port's bit set.
- R11: A final status read sets `link_map[p]` exactly when the detect field equals 3.
- R12: After the last port, host control is read and written back with bit 1 (interrupt enable) set, and then `done` rises.
- R13: `bus_req` stays high with stable address, direction and write data until `bus_ack`, with one access outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per millisecond |
| start | input | 1 | Begin a bring-up run |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 8 | Register word address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access complete; read data valid |
| bus_rdata | input | 32 | Read data |
| done | output | 1 | Run finished (level until next start) |
| fail | output | 1 | Controller reset never completed |
| link_map | output | MAX_PORTS | One bit per port with a live link |

## Verification
The bench models the controller with shrunken budgets and goes after the poll limits. It uses a reset that never clears, a link that never arrives, and a device that stays busy while its link flaps to a non-ready code. A design off by one in any counter would show a wrong read count there. Ports that raise the reset-handshake code once, or more often than the retry cap, would expose a sequencer that loops forever or never retries. A clamped port count and a mask with holes would catch a design that walks past the implemented ports. Read-modify-write values on the command, error and interrupt registers would catch a design that drops neighbouring bits or clears error status it never read.

// File: rtl/sata_bringup_pkg.sv
package sata_bringup_pkg;

    typedef logic [7:0]  addr_t;
    typedef logic [31:0] word_t;

    // host-level registers
    localparam addr_t H_CAP  = 8'h00;
    localparam addr_t H_CTL  = 8'h01;
    localparam addr_t H_IMPL = 8'h02;
    localparam addr_t H_IRQ  = 8'h03;
    localparam addr_t PORT_BASE = 8'h10;

    // per-port register offsets
    localparam logic [2:0] P_CMD  = 3'd0;
    localparam logic [2:0] P_STAT = 3'd1;
    localparam logic [2:0] P_ERR  = 3'd2;
    localparam logic [2:0] P_TFD  = 3'd3;
    localparam logic [2:0] P_IRQ  = 3'd4;

    localparam word_t CTL_RST_M   = 32'h0000_0001;
    localparam word_t CTL_IE_M    = 32'h0000_0002;
    localparam word_t CMD_SPIN_M  = 32'h0000_0002;
    localparam word_t CMD_ACTIVE_M = 32'h0000_C011;

    localparam logic [3:0] DET_READY = 4'd3;
    localparam logic [3:0] DET_RESET = 4'd1;

    typedef struct packed {
        logic  we;
        addr_t addr;
        word_t wdata;
    } bus_op_t;

    typedef enum logic [4:0] {
        S_IDLE, S_H_RD_CTL, S_H_WR_RST, S_H_WAIT_RST, S_H_POLL_RST,
        S_H_RD_CAP, S_H_RD_IMPL, S_P_PICK, S_P_RD_CMD, S_P_WR_DEACT,
        S_P_WAIT_DEACT, S_P_RD_CMD2, S_P_WR_SPIN, S_P_RD_LINK, S_P_WAIT_LINK,
        S_P_RD_ERR, S_P_WR_ERR, S_P_RD_TFD, S_P_WAIT_SPIN, S_P_RD_DET_SPIN,
        S_P_RD_DET_END, S_P_RD_ERR2, S_P_WR_ERR2, S_P_RD_IRQ, S_P_WR_IRQ,
        S_P_WR_HIRQ, S_P_RD_DET_MAP, S_H_RD_CTL2, S_H_WR_IE
    } seq_state_t;

    function automatic addr_t port_reg(input logic [4:0] idx, input logic [2:0] off);
        return PORT_BASE + {idx, 3'b000} + {5'b00000, off};
    endfunction

    function automatic logic tfd_ready(input word_t v);
        return !(v[7] || v[3]);
    endfunction

endpackage

// File: rtl/sata_bringup_bus_master.sv
module sata_bringup_bus_master
    import sata_bringup_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    go,
    input  bus_op_t op,
    output logic    bus_req,
    output logic    bus_we,
    output addr_t   bus_addr,
    output word_t   bus_wdata,
    input  logic    bus_ack,
    input  word_t   bus_rdata,
    output logic    acc_done,
    output word_t   acc_rdata
);
    bus_op_t op_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_req <= 1'b0;
            op_q    <= '0;
        end else if (!bus_req && go) begin
            bus_req <= 1'b1;
            op_q    <= op;
        end else if (bus_req && bus_ack) begin
            bus_req <= 1'b0;
        end
    end

    assign bus_we    = op_q.we;
    assign bus_addr  = op_q.addr;
    assign bus_wdata = op_q.wdata;
    assign acc_done  = bus_req && bus_ack;
    assign acc_rdata = bus_rdata;
endmodule

// File: rtl/sata_bringup_counter.sv
module sata_bringup_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            value <= '0;
        else if (inc)
            value <= value + 1'b1;
    end
endmodule

// File: rtl/sata_bringup_port_picker.sv
module sata_bringup_port_picker #(
    parameter int MAX_PORTS = 8,
    parameter int IDX_W = 3,
    parameter int LIM_W = 4
) (
    input  logic [MAX_PORTS-1:0] mask,
    input  logic [LIM_W-1:0]     limit,
    input  logic [LIM_W-1:0]     from,
    output logic                 found,
    output logic [IDX_W-1:0]     idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = MAX_PORTS - 1; i >= 0; i--) begin
            if (LIM_W'(i) >= from && LIM_W'(i) < limit && mask[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/sata_bringup_seq.sv
module sata_bringup_seq
    import sata_bringup_pkg::*;
#(
    parameter int MAX_PORTS   = 8,
    parameter int RST_POLLS   = 1000,
    parameter int LINK_POLLS  = 200,
    parameter int SPIN_POLLS  = 20000,
    parameter int DEACT_TICKS = 500,
    parameter int MAX_RETRY   = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 start,
    output logic                 bus_req,
    output logic                 bus_we,
    output logic [7:0]           bus_addr,
    output logic [31:0]          bus_wdata,
    input  logic                 bus_ack,
    input  logic [31:0]          bus_rdata,
    output logic                 done,
    output logic                 fail,
    output logic [MAX_PORTS-1:0] link_map
);
    localparam int IDX_W = (MAX_PORTS > 1) ? $clog2(MAX_PORTS) : 1;
    localparam int LIM_W = IDX_W + 1;
    localparam int MAX_AB  = (RST_POLLS > LINK_POLLS) ? RST_POLLS : LINK_POLLS;
    localparam int MAX_CD  = (SPIN_POLLS > DEACT_TICKS) ? SPIN_POLLS : DEACT_TICKS;
    localparam int CNT_MAX = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W = $clog2(CNT_MAX + 1);
    localparam int RTY_W = $clog2(MAX_RETRY + 2);
    localparam logic [CNT_W-1:0] RST_LAST   = CNT_W'(RST_POLLS - 1);
    localparam logic [CNT_W-1:0] LINK_LAST  = CNT_W'(LINK_POLLS - 1);
    localparam logic [CNT_W-1:0] SPIN_LAST  = CNT_W'(SPIN_POLLS - 1);
    localparam logic [CNT_W-1:0] DEACT_LAST = CNT_W'(DEACT_TICKS - 1);
    localparam logic [RTY_W-1:0] RTY_CAP    = RTY_W'(MAX_RETRY);

    seq_state_t state, state_n;
    bus_op_t    op;
    logic       acc_state, go, acc_done;
    word_t      rd, hold;
    logic [3:0] det;
    logic [CNT_W-1:0] cnt;
    logic       cnt_clr, cnt_inc;
    logic [IDX_W-1:0] cur, pick_idx;
    logic [LIM_W-1:0] limit_q, from_q, lim_n;
    logic [MAX_PORTS-1:0] impl_q;
    logic       pick_found;
    logic [RTY_W-1:0] retry_q;
    logic       done_q, fail_q, rst_timeout, do_retry;
    logic [MAX_PORTS-1:0] map_q;
    logic [4:0] pa;

    assign det = rd[3:0];
    assign pa  = 5'(cur);
    assign go  = acc_state && !bus_req;
    assign rst_timeout = (state == S_H_POLL_RST) && acc_done && rd[0] && (cnt == RST_LAST);
    assign do_retry = (det == DET_RESET) && (retry_q < RTY_CAP);

    sata_bringup_bus_master u_bus (
        .clk(clk), .rst(rst), .go(go), .op(op),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .acc_done(acc_done), .acc_rdata(rd)
    );

    sata_bringup_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc), .value(cnt)
    );

    sata_bringup_port_picker #(.MAX_PORTS(MAX_PORTS), .IDX_W(IDX_W), .LIM_W(LIM_W)) u_pick (
        .mask(impl_q), .limit(limit_q), .from(from_q), .found(pick_found), .idx(pick_idx)
    );

    // clamp of the advertised port count
    always_comb begin
        if ({1'b0, rd[4:0]} + 6'd1 > 6'(MAX_PORTS))
            lim_n = LIM_W'(MAX_PORTS);
        else
            lim_n = LIM_W'({1'b0, rd[4:0]} + 6'd1);
    end

    // access issued in each state
    always_comb begin
        op = '0;
        acc_state = 1'b1;
        case (state)
            S_H_RD_CTL, S_H_POLL_RST, S_H_RD_CTL2: op.addr = H_CTL;
            S_H_WR_RST:     op = '{1'b1, H_CTL, hold | CTL_RST_M};
            S_H_WR_IE:      op = '{1'b1, H_CTL, hold | CTL_IE_M};
            S_H_RD_CAP:     op.addr = H_CAP;
            S_H_RD_IMPL:    op.addr = H_IMPL;
            S_P_RD_CMD, S_P_RD_CMD2: op.addr = port_reg(pa, P_CMD);
            S_P_WR_DEACT:   op = '{1'b1, port_reg(pa, P_CMD), hold & ~CMD_ACTIVE_M};
            S_P_WR_SPIN:    op = '{1'b1, port_reg(pa, P_CMD), hold | CMD_SPIN_M};
            S_P_RD_LINK, S_P_RD_DET_SPIN, S_P_RD_DET_END, S_P_RD_DET_MAP:
                            op.addr = port_reg(pa, P_STAT);
            S_P_RD_ERR, S_P_RD_ERR2: op.addr = port_reg(pa, P_ERR);
            S_P_WR_ERR, S_P_WR_ERR2: op = '{1'b1, port_reg(pa, P_ERR), hold};
            S_P_RD_TFD:     op.addr = port_reg(pa, P_TFD);
            S_P_RD_IRQ:     op.addr = port_reg(pa, P_IRQ);
            S_P_WR_IRQ:     op = '{1'b1, port_reg(pa, P_IRQ), hold};
            S_P_WR_HIRQ:    op = '{1'b1, H_IRQ, word_t'(1) << cur};
            default:        acc_state = 1'b0;
        endcase
    end

    // sequencing
    always_comb begin
        state_n = state;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        case (state)
            S_IDLE:       if (start) state_n = S_H_RD_CTL;
            S_H_RD_CTL:   if (acc_done) state_n = S_H_WR_RST;
            S_H_WR_RST:   if (acc_done) begin cnt_clr = 1'b1; state_n = S_H_WAIT_RST; end
            S_H_WAIT_RST: if (tick) state_n = S_H_POLL_RST;
            S_H_POLL_RST: if (acc_done) begin
                if (!rd[0])             state_n = S_H_RD_CAP;
                else if (cnt == RST_LAST) state_n = S_IDLE;
                else begin cnt_inc = 1'b1; state_n = S_H_WAIT_RST; end
            end
            S_H_RD_CAP:   if (acc_done) state_n = S_H_RD_IMPL;
            S_H_RD_IMPL:  if (acc_done) state_n = S_P_PICK;
            S_P_PICK:     state_n = pick_found ? S_P_RD_CMD : S_H_RD_CTL2;
            S_P_RD_CMD:   if (acc_done)
                state_n = ((rd & CMD_ACTIVE_M) != '0) ? S_P_WR_DEACT : S_P_RD_CMD2;
            S_P_WR_DEACT: if (acc_done) begin cnt_clr = 1'b1; state_n = S_P_WAIT_DEACT; end
            S_P_WAIT_DEACT: if (tick) begin
                if (cnt == DEACT_LAST) state_n = S_P_RD_CMD2;
                else cnt_inc = 1'b1;
            end
            S_P_RD_CMD2:  if (acc_done) state_n = S_P_WR_SPIN;
            S_P_WR_SPIN:  if (acc_done) begin cnt_clr = 1'b1; state_n = S_P_RD_LINK; end
            S_P_RD_LINK:  if (acc_done) begin
                if (det == DET_READY)      begin cnt_clr = 1'b1; state_n = S_P_RD_ERR; end
                else if (cnt == LINK_LAST) state_n = S_P_PICK;
                else begin cnt_inc = 1'b1; state_n = S_P_WAIT_LINK; end
            end
            S_P_WAIT_LINK: if (tick) state_n = S_P_RD_LINK;
            S_P_RD_ERR:   if (acc_done) state_n = (rd != '0) ? S_P_WR_ERR : S_P_RD_TFD;
            S_P_WR_ERR:   if (acc_done) state_n = S_P_RD_TFD;
            S_P_RD_TFD:   if (acc_done) state_n = tfd_ready(rd) ? S_P_RD_DET_END : S_P_WAIT_SPIN;
            S_P_WAIT_SPIN: if (tick) state_n = S_P_RD_DET_SPIN;
            S_P_RD_DET_SPIN: if (acc_done) begin
                if (det == DET_READY || cnt == SPIN_LAST) state_n = S_P_RD_DET_END;
                else begin cnt_inc = 1'b1; state_n = S_P_RD_TFD; end
            end
            S_P_RD_DET_END: if (acc_done) state_n = do_retry ? S_P_RD_CMD : S_P_RD_ERR2;
            S_P_RD_ERR2:  if (acc_done) state_n = S_P_WR_ERR2;
            S_P_WR_ERR2:  if (acc_done) state_n = S_P_RD_IRQ;
            S_P_RD_IRQ:   if (acc_done) state_n = (rd != '0) ? S_P_WR_IRQ : S_P_WR_HIRQ;
            S_P_WR_IRQ:   if (acc_done) state_n = S_P_WR_HIRQ;
            S_P_WR_HIRQ:  if (acc_done) state_n = S_P_RD_DET_MAP;
            S_P_RD_DET_MAP: if (acc_done) state_n = S_P_PICK;
            S_H_RD_CTL2:  if (acc_done) state_n = S_H_WR_IE;
            S_H_WR_IE:    if (acc_done) state_n = S_IDLE;
            default:      state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            hold    <= '0;
            cur     <= '0;
            limit_q <= '0;
            from_q  <= '0;
            impl_q  <= '0;
            retry_q <= '0;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
            map_q   <= '0;
        end else begin
            state <= state_n;
            if (acc_done && !bus_we)
                hold <= rd;
            if (state == S_IDLE && start) begin
                done_q <= 1'b0;
                fail_q <= 1'b0;
                map_q  <= '0;
            end
            if (rst_timeout) begin
                done_q <= 1'b1;
                fail_q <= 1'b1;
            end
            if (state == S_H_RD_CAP && acc_done)
                limit_q <= lim_n;
            if (state == S_H_RD_IMPL && acc_done) begin
                impl_q <= rd[MAX_PORTS-1:0];
                from_q <= '0;
            end
            if (state == S_P_PICK && pick_found) begin
                cur     <= pick_idx;
                from_q  <= LIM_W'(pick_idx) + 1'b1;
                retry_q <= '0;
            end
            if (state == S_P_RD_DET_END && acc_done && do_retry)
                retry_q <= retry_q + 1'b1;
            if (state == S_P_RD_DET_MAP && acc_done && det == DET_READY)
                map_q[cur] <= 1'b1;
            if (state == S_H_WR_IE && acc_done)
                done_q <= 1'b1;
        end
    end

    assign done     = done_q;
    assign fail     = fail_q;
    assign link_map = map_q;
endmodule

// File: rtl/sata_bringup_seq_chk.sv
module sata_bringup_seq_chk #(
    parameter int MAX_PORTS = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic                 bus_req,
    input logic                 bus_we,
    input logic [7:0]           bus_addr,
    input logic [31:0]          bus_wdata,
    input logic                 bus_ack,
    input logic                 done,
    input logic                 fail,
    input logic [MAX_PORTS-1:0] link_map
);
    // R13
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> bus_req);
    // R13
    req_stable_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));
    // R2
    fail_done_chk: assert property (@(posedge clk) disable iff (rst)
        fail |-> done);
    // R12
    idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !bus_req);
    // R10
    hirq_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_we && bus_addr == 8'h03 |-> $countones(bus_wdata) == 1);
    // R3
    port_range_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_addr >= 8'h10 |-> 32'((bus_addr - 8'h10) >> 3) < MAX_PORTS);
    // R1
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> done && $stable(link_map) && $stable(fail));
endmodule

bind sata_bringup_seq sata_bringup_seq_chk #(.MAX_PORTS(MAX_PORTS)) u_chk (
    .clk(clk), .rst(rst), .start(start), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .done(done), .fail(fail), .link_map(link_map)
);

// File: tb/sata_bringup_seq_test.sv
module sata_bringup_seq_test;
    localparam int NP = 4, RSTP = 6, LINKP = 5, SPINP = 7, DEACTP = 3, RTY = 2, LAT = 2;
    localparam int NEVER = 1000000;

    logic clk = 0, rst = 1, tick = 0, start = 0, bus_ack = 0, cfg_load = 0;
    logic bus_req, bus_we, done, fail;
    logic [7:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata = 0;
    logic [NP-1:0] link_map;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    sata_bringup_seq #(.MAX_PORTS(NP), .RST_POLLS(RSTP), .LINK_POLLS(LINKP),
        .SPIN_POLLS(SPINP), .DEACT_TICKS(DEACTP), .MAX_RETRY(RTY)) uut (
        .clk(clk), .rst(rst), .tick(tick), .start(start), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .done(done), .fail(fail), .link_map(link_map));

    // scenario configuration (written by the stimulus only)
    logic [31:0] c_cap, c_impl, c_cmd[NP], c_err[NP], c_irq[NP];
    int c_link[NP], c_cominit[NP];
    bit c_flap[NP], c_busy[NP], c_stuck;

    // controller model state (written by the responder only)
    logic [31:0] cmd_r[NP], err_r[NP], irq_r[NP], spin_wd[NP], deact_wd[NP], errwb_wd[NP], irqwb_wd[NP];
    int stat_rd[NP], tfd_rd[NP], spin_wr[NP], deact_wr[NP], acc[NP], errwb[NP], irqwb[NP];
    int spin_tick[NP], since[NP], cominit[NP], deact_tick[NP], deact_gap[NP];
    bit spun[NP];
    logic [NP-1:0] hirq;
    int ticks, ctl_rd, cap_rd, rst_left, last_p, order_bad, hs_bad, bad_addr, wait_c, cyc;
    bit ctl_ie;
    logic [7:0] cap_a; logic cap_we; logic [31:0] cap_wd;

    function automatic logic [3:0] det_of(int p);
        if (!spun[p] || ticks - spin_tick[p] < c_link[p]) return 4'd0;
        if (c_flap[p] && since[p] >= 1) return 4'd2;
        if (cominit[p] > 0 && since[p] == 1) return 4'd1;
        return 4'd3;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        tick <= (cyc % 4 == 2);
        if (tick) begin
            ticks = ticks + 1;
            if (rst_left > 0) rst_left = rst_left - 1;
        end
        if (cfg_load) begin
            for (int p = 0; p < NP; p++) begin
                cmd_r[p] = c_cmd[p]; err_r[p] = c_err[p]; irq_r[p] = c_irq[p];
                stat_rd[p] = 0; tfd_rd[p] = 0; spin_wr[p] = 0; deact_wr[p] = 0; acc[p] = 0;
                errwb[p] = 0; irqwb[p] = 0; spun[p] = 0; since[p] = 0; cominit[p] = c_cominit[p];
                deact_tick[p] = -1; deact_gap[p] = -1; spin_wd[p] = 0; deact_wd[p] = 0;
                errwb_wd[p] = 0; irqwb_wd[p] = 0;
            end
            hirq = 0; ctl_rd = 0; cap_rd = 0; rst_left = 0; last_p = 0; order_bad = 0;
            hs_bad = 0; bad_addr = 0; ctl_ie = 0;
        end
        bus_ack <= 1'b0;
        if (bus_req && !bus_ack) begin
            if (wait_c == 0) begin cap_a = bus_addr; cap_we = bus_we; cap_wd = bus_wdata; end
            else if (cap_a != bus_addr || cap_we != bus_we || cap_wd != bus_wdata) hs_bad = hs_bad + 1;
            if (wait_c < LAT) wait_c = wait_c + 1;
            else begin
                wait_c = 0;
                bus_ack <= 1'b1;
                bus_rdata <= 32'h0;
                if (bus_addr < 8'h10) begin
                    case (bus_addr)
                        8'h00: begin cap_rd = cap_rd + 1; bus_rdata <= c_cap; end
                        8'h01: if (bus_we) begin
                                   if (bus_wdata[0]) rst_left = 2;
                                   ctl_ie = bus_wdata[1];
                               end else begin
                                   ctl_rd = ctl_rd + 1;
                                   bus_rdata <= {30'd0, ctl_ie, c_stuck || rst_left > 0};
                               end
                        8'h02: bus_rdata <= c_impl;
                        8'h03: if (bus_we) hirq = hirq | bus_wdata[NP-1:0];
                        default: bad_addr = bad_addr + 1;
                    endcase
                end else begin
                    automatic int p = int'(bus_addr - 8'h10) >> 3;
                    if (p >= NP) bad_addr = bad_addr + 1;
                    else begin
                        acc[p] = acc[p] + 1;
                        if (p < last_p) order_bad = order_bad + 1;
                        last_p = p;
                        case (bus_addr[2:0])
                            3'd0: if (bus_we) begin
                                      if (bus_wdata[1]) begin
                                          spin_wr[p] = spin_wr[p] + 1; spin_wd[p] = bus_wdata;
                                          spun[p] = 1; spin_tick[p] = ticks; since[p] = 0;
                                      end else begin
                                          deact_wr[p] = deact_wr[p] + 1; deact_wd[p] = bus_wdata;
                                          deact_tick[p] = ticks;
                                      end
                                      cmd_r[p] = bus_wdata;
                                  end else begin
                                      if (deact_tick[p] >= 0 && deact_gap[p] < 0)
                                          deact_gap[p] = ticks - deact_tick[p];
                                      bus_rdata <= cmd_r[p];
                                  end
                            3'd1: begin
                                      automatic logic [3:0] d = det_of(p);
                                      if (d == 4'd1) cominit[p] = cominit[p] - 1;
                                      stat_rd[p] = stat_rd[p] + 1; since[p] = since[p] + 1;
                                      bus_rdata <= {28'd0, d};
                                  end
                            3'd2: if (bus_we) begin
                                      errwb[p] = errwb[p] + 1; errwb_wd[p] = bus_wdata;
                                      err_r[p] = err_r[p] & ~bus_wdata;
                                  end else bus_rdata <= err_r[p];
                            3'd3: begin
                                      tfd_rd[p] = tfd_rd[p] + 1;
                                      bus_rdata <= c_busy[p] ? 32'h80 : 32'h50;
                                  end
                            3'd4: if (bus_we) begin
                                      irqwb[p] = irqwb[p] + 1; irqwb_wd[p] = bus_wdata;
                                      irq_r[p] = irq_r[p] & ~bus_wdata;
                                  end else bus_rdata <= irq_r[p];
                            default: bad_addr = bad_addr + 1;
                        endcase
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg_default();
        c_cap = 32'd3; c_impl = 32'hF; c_stuck = 0;
        for (int p = 0; p < NP; p++) begin
            c_cmd[p] = 0; c_err[p] = 0; c_irq[p] = 0; c_link[p] = 0;
            c_cominit[p] = 0; c_flap[p] = 0; c_busy[p] = 0;
        end
    endtask

    task automatic load_and_run(input bit extra_start);
        @(negedge clk) cfg_load = 1;
        @(negedge clk) cfg_load = 0;
        start = 1;
        @(negedge clk) start = 0;
        chk(done == 0, "R1 done cleared by start", done, 0);
        if (extra_start) begin
            repeat (30) @(negedge clk);
            start = 1;
            @(negedge clk) start = 0;
        end
        for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    endtask

    initial begin
        cyc = 0; ticks = 0; wait_c = 0;
        cfg_default();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(done == 0 && fail == 0 && link_map == 0 && bus_req == 0, "R1 reset state",
            {done, fail, bus_req, link_map}, 0);

        // scenario 1: mixed ports, hole in mask, active port, slow link, dead link
        cfg_default();
        c_impl = 32'hB;
        c_cmd[0] = 32'hC111; c_err[0] = 32'h55; c_irq[0] = 32'h9;
        c_cmd[1] = 32'h0100; c_link[1] = 3;
        c_link[3] = NEVER;
        load_and_run(0);
        chk(done && !fail, "R12 run completes", {done, fail}, 2);
        chk(link_map == 4'b0011, "R11 link map", link_map, 3);
        chk(acc[2] == 0, "R3 unimplemented port untouched", acc[2], 0);
        chk(order_bad == 0, "R3 ascending order", order_bad, 0);
        chk(deact_wr[0] == 1 && deact_wd[0] == 32'h0100, "R4 deactivate value", deact_wd[0], 32'h0100);
        chk(deact_gap[0] >= DEACTP, "R4 deactivate wait", deact_gap[0], DEACTP);
        chk(deact_wr[1] == 0, "R4 idle port not deactivated", deact_wr[1], 0);
        chk(spin_wd[0] == 32'h0102 && spin_wd[1] == 32'h0102, "R5 spin-up keeps bits", spin_wd[1], 32'h0102);
        chk(stat_rd[3] == LINKP, "R6 link poll budget", stat_rd[3], LINKP);
        chk(tfd_rd[3] == 0 && errwb[3] == 0 && irqwb[3] == 0, "R6 dead port skipped", tfd_rd[3] + errwb[3], 0);
        chk(link_map[1] == 1, "R6 late link accepted", link_map[1], 1);
        chk(errwb[0] == 2 && errwb[1] == 1, "R7 R10 error write-backs", errwb[0] * 10 + errwb[1], 21);
        chk(irqwb[0] == 1 && irqwb_wd[0] == 32'h9 && irqwb[1] == 0, "R10 interrupt write-back", irqwb_wd[0], 9);
        chk(hirq == 4'b0011, "R10 host interrupt bits", hirq, 3);
        chk(ctl_ie == 1, "R12 interrupt enable", ctl_ie, 1);
        chk(hs_bad == 0 && bad_addr == 0, "R13 handshake stable", hs_bad + bad_addr, 0);

        // scenario 2: controller reset never completes
        cfg_default();
        c_stuck = 1;
        load_and_run(0);
        chk(done && fail, "R2 reset timeout fails", {done, fail}, 3);
        chk(ctl_rd == 1 + RSTP, "R2 reset poll count", ctl_rd, 1 + RSTP);
        chk(cap_rd == 0 && acc[0] + acc[1] + acc[2] + acc[3] == 0, "R2 no port access", cap_rd, 0);
        chk(link_map == 0, "R2 empty map", link_map, 0);

        // scenario 3: clamped count, retries, busy device with flapping link
        cfg_default();
        c_cap = 32'h1F;
        c_cominit[0] = 1;
        c_cominit[1] = 9;
        c_flap[2] = 1; c_busy[2] = 1;
        load_and_run(0);
        chk(acc[3] > 0, "R3 clamp to port limit", acc[3], 1);
        chk(spin_wr[0] == 2, "R9 single retry", spin_wr[0], 2);
        chk(spin_wr[1] == RTY + 1, "R9 retry cap", spin_wr[1], RTY + 1);
        chk(tfd_rd[2] == SPINP, "R8 device wait budget", tfd_rd[2], SPINP);
        chk(spin_wr[2] == 1, "R9 no retry on other codes", spin_wr[2], 1);
        chk(link_map == 4'b1011, "R11 map after retries", link_map, 11);
        chk(!fail, "R6 R8 timeouts are not fatal", fail, 0);

        // scenario 4: two ports advertised, start pulsed mid-run
        cfg_default();
        c_cap = 32'd1;
        load_and_run(1);
        chk(acc[2] == 0 && acc[3] == 0, "R3 port count from capability", acc[2] + acc[3], 0);
        chk(link_map == 4'b0011, "R11 two-port map", link_map, 3);
        chk(cap_rd == 1, "R1 start ignored while busy", cap_rd, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule